// File: doc/BRIEF.md
# Current-Budgeted Phase-Change Line Write Scheduler

This block programs one cache line into a phase-change array, which is modelled here as a register file, without exceeding a fixed current budget in any time slot. When a write starts, the block compares the new line with the old contents. Only bits whose value differs are programmed: old 0 to new 1 is a SET, and old 1 to new 0 is a RESET. Each data unit is then costed by its real number of changed bits. The block does not assume that every bit in a unit toggles.

SET pulses are long and are placed first. At the start of each SET round, whole units with pending SET bits are admitted in index order, as far as the budget allows. The admitted pulse is then held for a fixed number of slots. In every slot, pending RESET units are admitted in index order into whatever current the running SET pulse leaves free. Each RESET lasts a single slot. The array side applies `set_mask` and `rst_mask` in every slot where `slot_valid` is high. `done` pulses once every changed bit has been written.

Top module: `pcm_write_sched`

## Requirements
- R1: A bit appears in `set_mask` only if it is 1 in `new_line` and 0 in `old_line`. A bit appears in `rst_mask` only if it is 0 in `new_line` and 1 in `old_line`. Unchanged bits are never driven.
- R2: In every slot, the current drawn must not exceed BUDGET (32). The current is popcount(`set_mask`)·SET_I (1) plus popcount(`rst_mask`)·RST_I (2). The parameters must satisfy UNIT_W·max(SET_I,RST_I) ≤ BUDGET.
- R3: Every bit that needs a SET is driven in exactly one run of SET_SLOTS (8) consecutive slots. Every bit that needs a RESET is driven in exactly one slot. No bit is driven as SET and RESET in the same slot.
- R4: SET rounds begin only after the previous SET pulse has ended. At each round start, units with pending SET bits are taken in ascending index order (unit u is bits u·16 to u·16+15). A unit whose cost does not fit the remaining budget is skipped, and later units may still be admitted.
- R5: In each slot, units with pending RESET bits are admitted in ascending index order, and a unit is skipped if it does not fit. A RESET unit is admitted only when its cost fits within BUDGET minus the current of the SET pulse running in that slot.
- R6: `slot_valid` is high in every busy cycle from the cycle after `start` until the last slot. `done` is a single-cycle pulse in the cycle after the last slot, with `slot_valid` low. A line with no changed bits raises `done` in the cycle after `start` and issues no slot.
- R7: A `start` that arrives while a write is in progress is ignored, and it changes neither the masks nor the slot count.
- R8: After reset, and while idle, `slot_valid`, `done`, `set_mask` and `rst_mask` are all zero.
- R9: Applying every slot's masks to an array that holds `old_line` leaves exactly `new_line` in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a line write when idle |
| new_line | input | 128 | Data to be stored |
| old_line | input | 128 | Current array contents |
| slot_valid | output | 1 | This cycle is a programming slot |
| set_mask | output | 128 | Bits receiving a SET pulse this slot |
| rst_mask | output | 128 | Bits receiving a RESET pulse this slot |
| done | output | 1 | All changed bits have been written |

## Verification
The bench uses the default parameters: 8 units of 16 bits, SET cost 1, RESET cost 2, budget 32 and an 8-slot SET pulse. With these values a single full unit of SETs fills half the budget, and a single full unit of RESETs fills all of it. Each fitting and skipping decision can therefore be forced with a few hand-built lines whose slot totals are known exactly: 32, 8, 8, 20 and 16. A long stream of pseudo-random lines with varied change densities then exercises the per-slot current bound, the exactly-once rule and the final contents.

// File: rtl/pcm_write_sched.sv
module pcm_write_sched #(
  parameter int UNITS     = 8,
  parameter int UNIT_W    = 16,
  parameter int SET_I     = 1,
  parameter int RST_I     = 2,
  parameter int BUDGET    = 32,
  parameter int SET_SLOTS = 8,
  localparam int LINE_W   = UNITS * UNIT_W,
  localparam int CW       = $clog2(SET_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] new_line,
  input  logic [LINE_W-1:0] old_line,
  output logic              slot_valid,
  output logic [LINE_W-1:0] set_mask,
  output logic [LINE_W-1:0] rst_mask,
  output logic              done
);

  logic              busy;
  logic [LINE_W-1:0] pend_set, pend_rst, act_set;
  logic [CW-1:0]     cnt;
  int                set_load;

  logic [LINE_W-1:0] new_set, rst_now;
  int                load_set;

  function automatic int ones(input logic [UNIT_W-1:0] v);
    int n = 0;
    for (int i = 0; i < UNIT_W; i++) n += int'(v[i]);
    return n;
  endfunction

  always_comb begin
    int acc;
    int c;
    new_set = '0;
    rst_now = '0;
    acc = 0;
    if (busy && cnt == '0) begin
      for (int u = 0; u < UNITS; u++) begin
        c = ones(pend_set[u*UNIT_W +: UNIT_W]) * SET_I;
        if (c > 0 && acc + c <= BUDGET) begin
          acc += c;
          new_set[u*UNIT_W +: UNIT_W] = pend_set[u*UNIT_W +: UNIT_W];
        end
      end
    end else begin
      acc = set_load;
    end
    load_set = acc;
    for (int u = 0; u < UNITS; u++) begin
      c = ones(pend_rst[u*UNIT_W +: UNIT_W]) * RST_I;
      if (busy && c > 0 && acc + c <= BUDGET) begin
        acc += c;
        rst_now[u*UNIT_W +: UNIT_W] = pend_rst[u*UNIT_W +: UNIT_W];
      end
    end
  end

  assign set_mask   = (cnt == '0) ? new_set : act_set;
  assign rst_mask   = rst_now;
  assign slot_valid = (|set_mask) || (|rst_mask);
  assign done       = busy && pend_set == '0 && pend_rst == '0 && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend_set <= '0;
      pend_rst <= '0;
      act_set  <= '0;
      cnt      <= '0;
      set_load <= 0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        pend_set <= new_line & ~old_line;
        pend_rst <= ~new_line & old_line;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      pend_set <= pend_set & ~new_set;
      pend_rst <= pend_rst & ~rst_now;
      if (cnt == '0) begin
        if (|new_set) begin
          cnt      <= CW'(SET_SLOTS - 1);
          act_set  <= new_set;
          set_load <= load_set;
        end
      end else begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          act_set  <= '0;
          set_load <= 0;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_write_sched_chk.sv
module pcm_write_sched_chk #(
  parameter int LINE_W    = 128,
  parameter int SET_I     = 1,
  parameter int RST_I     = 2,
  parameter int BUDGET    = 32,
  parameter int SET_SLOTS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_valid,
  input logic [LINE_W-1:0] set_mask,
  input logic [LINE_W-1:0] rst_mask,
  input logic              done
);

  logic [LINE_W-1:0] prev_set;
  int                hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_set <= '0;
      hold     <= 0;
    end else begin
      prev_set <= set_mask;
      if (set_mask == '0)             hold <= 0;
      else if (set_mask == prev_set)  hold <= hold + 1;
      else                            hold <= 1;
    end
  end

  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> ($countones(set_mask) * SET_I + $countones(rst_mask) * RST_I <= BUDGET)); // R2

  AST_SET_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_set != '0 && set_mask != prev_set) |-> (hold == SET_SLOTS)); // R3

  AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask & rst_mask) == '0); // R3

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !slot_valid); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

bind pcm_write_sched pcm_write_sched_chk #(
  .LINE_W(LINE_W), .SET_I(SET_I), .RST_I(RST_I), .BUDGET(BUDGET), .SET_SLOTS(SET_SLOTS)
) chk_i (.*);

// File: tb/pcm_write_sched_tb_top.sv
module pcm_write_sched_tb_top;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] new_line = '0, old_line = '0;
  logic         slot_valid, done;
  logic [W-1:0] set_mask, rst_mask;

  int checks = 0, failures = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  pcm_write_sched dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .new_line(new_line), .old_line(old_line),
    .slot_valid(slot_valid), .set_mask(set_mask), .rst_mask(rst_mask), .done(done));

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic rnd_line(output logic [W-1:0] v, input int dens);
    for (int i = 0; i < W; i++) begin
      lfsr = step(lfsr);
      v[i] = (lfsr[7:0] < 8'(dens));
    end
  endtask

  task automatic run_line(input logic [W-1:0] nl, input logic [W-1:0] ol, input int exp_slots,
                          input logic [W-1:0] exp_first_set, input bit poke);
    logic [W-1:0] arr, prev_s, need_s, need_r;
    int setcnt[W], setrise[W], rstcnt[W];
    int slots = 0, cyc = 0, done_cyc = -1;
    bit bud_ok = 1, sub_ok = 1, once_ok = 1, first_ok = 1, cont_ok = 1, seen_gap = 0;
    arr = ol; prev_s = '0;
    need_s = nl & ~ol; need_r = ~nl & ol;
    for (int i = 0; i < W; i++) begin setcnt[i] = 0; setrise[i] = 0; rstcnt[i] = 0; end
    @(negedge clk);
    new_line = nl; old_line = ol; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cyc < 0 && cyc < 500) begin
      cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; new_line = ~nl; old_line = nl;
      end else begin
        start = 1'b0;
      end
      if (slot_valid) begin
        if (seen_gap) cont_ok = 0;
        slots++;
        if ($countones(set_mask) + 2 * $countones(rst_mask) > 32) bud_ok = 0;
        if ((set_mask & ~need_s) != '0 || (rst_mask & ~need_r) != '0) sub_ok = 0;
        if (slots == 1 && exp_first_set != '0 && set_mask != exp_first_set) first_ok = 0;
        for (int i = 0; i < W; i++) begin
          if (set_mask[i]) setcnt[i]++;
          if (set_mask[i] && !prev_s[i]) setrise[i]++;
          if (rst_mask[i]) rstcnt[i]++;
        end
        arr = (arr | set_mask) & ~rst_mask;
      end else begin
        seen_gap = 1;
      end
      prev_s = set_mask;
      if (done) done_cyc = cyc;
      @(negedge clk);
    end
    start = 1'b0;
    check(done_cyc > 0, "R6 watchdog/done", W'(cyc), W'(500));
    check(bud_ok, "R2 slot current within budget", '0, '0);
    check(sub_ok, "R1 only changed bits driven", '0, '0);
    for (int i = 0; i < W; i++) begin
      if (setcnt[i] != (need_s[i] ? 8 : 0) || setrise[i] != (need_s[i] ? 1 : 0) ||
          rstcnt[i] != (need_r[i] ? 1 : 0)) once_ok = 0;
    end
    check(once_ok, "R3 each bit pulsed exactly once", need_s, need_r);
    check(arr == nl, "R9 final array contents", arr, nl);
    check(done_cyc == slots + 1 && cont_ok, "R6 done one cycle after last slot", W'(done_cyc), W'(slots + 1));
    if (exp_slots >= 0)
      check(slots == exp_slots, poke ? "R7 start while busy ignored" : "R4/R5 slot count", W'(slots), W'(exp_slots));
    check(first_ok, "R4 greedy index-order admission", '0, exp_first_set);
    check(!slot_valid && !done && set_mask == '0 && rst_mask == '0, "R8 idle outputs", set_mask, '0);
  endtask

  function automatic logic [W-1:0] rep(input logic [15:0] u);
    return {8{u}};
  endfunction

  initial begin
    logic [W-1:0] a, b, fo, fn, ff;
    repeat (3) @(negedge clk);
    check(!slot_valid && !done && set_mask == '0 && rst_mask == '0, "R8 reset state", rst_mask, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!slot_valid && !done && set_mask == '0 && rst_mask == '0, "R8 idle after reset", set_mask, '0);

    run_line({W{1'b1}}, '0, 32, '0, 0);                       // R4: two full SET units per round
    run_line('0, {W{1'b1}}, 8, '0, 0);                        // R5: one full RESET unit per slot
    run_line(rep(16'h0003), rep(16'h00F0), 8, rep(16'h0003), 0); // R5: RESETs fill SET headroom
    run_line(rep(16'h00FF), rep(16'hFF00), 20, '0, 0);        // R4 R5 mixed
    run_line(rep(16'h5A5A), rep(16'h5A5A), 0, '0, 0);         // R6 no change
    fo = '0;
    fn = '0;
    fn[15:0]   = 16'h0FFF;
    fn[31:16]  = 16'hFFFF;
    fn[47:32]  = 16'hFFFF;
    fn[63:48]  = 16'h000F;
    fn[79:64]  = 16'hFFFF;
    ff = '0;
    ff[31:0] = fn[31:0];
    ff[63:48] = 16'h000F;
    run_line(fn, fo, 16, ff, 0);                              // R4 skip of unit 2, unit 3 admitted
    run_line({W{1'b1}}, '0, 32, '0, 1);                       // R7 start while busy

    for (int t = 0; t < 200; t++) begin
      rnd_line(a, 40 + (t % 6) * 40);
      rnd_line(b, 40 + ((t / 6) % 6) * 40);
      run_line(a, b, -1, '0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule